// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one packed control word from a host into a complete NAND flash bus operation. When the host writes a control word with its go bit set, the sequencer takes a snapshot of that word and of the current configuration. The configuration is the confirm register, the address registers, the data length and the strobe time. The sequencer then drives the flash pins through a fixed order of phases. First comes an opcode cycle with CLE. Next come zero to eight address cycles with ALE, least significant byte first. Then, depending on the direction, either a confirm opcode, a wait on the ready/busy line and a read phase, or a write phase, a confirm opcode and a wait.

Read bytes go into a local page buffer through a simple write port. Write bytes are taken from the same buffer through a combinational read port. A two-stage flash operation such as page program or block erase is carried by a single launch: the second opcode sits in the confirm register and is sent at the right point in the same run. Two sticky flags report the end of the run: one for the command and one for the data transfer. A third sticky flag records a launch that was attempted while the block was busy.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset the block is idle. Both chip enables are high (inactive), WE# and RE# are high, CLE and ALE are low, and every flag output is 0.
- R2: A launch happens only when cmd_wr is high with cmd_word bit 31 set while the block is idle. The first bus cycle then presents cmd_word[7:0] with CLE high. A cmd_wr with bit 31 clear produces no bus activity.
- R3: When cmd_word bit 30 is set, the opcode cycle is followed by (cmd_word[29:27] + 1) address cycles with ALE high. Each cycle carries one byte of {cfg_addr_hi, cfg_addr_lo}, starting at bits 7:0. When bit 30 is clear, no address cycle is issued.
- R4: While busy, exactly one chip enable is low. nf_ce_n[1] is driven low when cmd_word bit 19 was set at launch, and nf_ce_n[0] otherwise.
- R5: When cfg_ctl2 bit 8 is set, a confirm cycle with opcode cfg_ctl2[7:0] is issued under CLE. It follows the address cycles on reads and on operations with no data phase, and it follows the write data on writes. After the confirm cycle the block waits for nf_rb_n to go low and then high again before it continues.
- R6: When cmd_word bit 26 is set, cfg_len bytes are read with RE# strobes and stored at buffer addresses 0 up to cfg_len-1. If bits 26 and 25 are both set, the operation is a read.
- R7: When only cmd_word bit 25 is set, buf_rdata for buffer addresses 0 up to cfg_len-1 is driven out on WE# strobes, with CLE and ALE both low.
- R8: Each WE# or RE# strobe stays low for exactly cfg_tstrobe+1 clocks. WE# and RE# are never low at the same time.
- R9: At the end of every launched run, irq_cmd_done is set. irq_xfer_done is also set when bit 26 or bit 25 was set, and stays 0 for a run with no data phase. Writing irq_clr bit 0 clears the command flag and bit 1 clears the transfer flag. A status or ID read (one address cycle, length 4) returns 4 bytes.
- R10: A launch attempted while busy is ignored, and err_busy is set and stays set until irq_clr bit 2 is written.
- R11: Holding seq_clr high returns the block to idle from any phase. It releases the chip enables and clears all three flags.
- R12: A direction bit with cfg_len of 0 skips the data phase, and the run still completes with both flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_clr | input | 1 | Synchronous return to idle, clears the flags |
| cmd_wr | input | 1 | Control word write strobe |
| cmd_word | input | 32 | Control word: go, address enable/count, direction, chip select, opcode |
| cfg_ctl2 | input | 9 | Confirm enable (bit 8) and confirm opcode (7:0) |
| cfg_addr_lo | input | 16 | Low address bits (column or low page bits) |
| cfg_addr_hi | input | 24 | Page bits that follow the low address bits |
| cfg_len | input | LEN_W | Data phase byte count |
| cfg_tstrobe | input | T_W | Strobe low/high time minus one, in clocks |
| irq_clr | input | 3 | Write-one-to-clear: command, transfer, error |
| busy | output | 1 | A run is in progress |
| irq_cmd_done | output | 1 | Sticky command-complete flag |
| irq_xfer_done | output | 1 | Sticky transfer-complete flag |
| err_busy | output | 1 | Sticky launch-while-busy flag |
| nf_ce_n | output | 2 | Chip enables, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Flash data bus out |
| nf_dq_oe | output | 1 | Flash data bus output enable |
| nf_dq_in | input | 8 | Flash data bus in |
| nf_rb_n | input | 1 | Ready/busy, low while busy |
| buf_addr | output | LEN_W | Page buffer byte address |
| buf_wr | output | 1 | Page buffer write enable (read phase) |
| buf_wdata | output | 8 | Page buffer write data |
| buf_rdata | input | 8 | Page buffer read data for buf_addr (write phase) |

## Verification
The assertions assume several things about the flash device. The ready/busy line must go low within a few clocks of a confirm cycle, and it must be stable for at least one full clock at a time. Read data must be valid by the last clock of an RE# low phase. The page buffer must return buf_rdata in the same cycle as buf_addr. The bench's flash model meets all of these. It pulls ready/busy low half a clock after each confirm opcode latches and holds it for twelve clocks. It drives new read data on every falling RE# edge. The page buffer content is a pure function of the address. The random stimulus keeps lengths, address counts and strobe times small, and uses only confirm opcodes that the model recognises as busy-causing.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_CMD, S_ADDR, S_CONF, S_WLO, S_WHI, S_DATA, S_FIN
   } seq_st_t;

   // control word field positions (decoded by the host side, so fixed)
   localparam int C1_GO    = 31;
   localparam int C1_AEN   = 30;
   localparam int C1_NA_LO = 27;
   localparam int C1_RD    = 26;
   localparam int C1_WR    = 25;
   localparam int C1_CS    = 19;
   localparam int C2_CONF  = 8;

endpackage

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen #(
   parameter int T_W = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           start,
   input  logic [T_W-1:0] tlen,
   output logic           active,
   output logic           low,
   output logic           sample,
   output logic           done
);

   logic           act_q;
   logic           hi_q;
   logic [T_W-1:0] cnt_q;
   logic [T_W-1:0] tl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         hi_q  <= 1'b0;
         cnt_q <= '0;
         tl_q  <= '0;
      end else if (clr) begin
         act_q <= 1'b0;
         hi_q  <= 1'b0;
         cnt_q <= '0;
      end else if (start && !act_q) begin
         act_q <= 1'b1;
         hi_q  <= 1'b0;
         cnt_q <= tlen;
         tl_q  <= tlen;
      end else if (act_q) begin
         if (cnt_q == '0) begin
            if (!hi_q) begin
               hi_q  <= 1'b1;
               cnt_q <= tl_q;
            end else begin
               act_q <= 1'b0;
            end
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign active = act_q;
   assign low    = act_q && !hi_q;
   assign sample = low && (cnt_q == '0);
   assign done   = act_q && hi_q && (cnt_q == '0);

   // R8
   low_ends_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
      sample |=> (active && !low));

endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
   parameter bit SYNC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rb_in,
   output logic rb_out
);

   generate
      if (SYNC) begin : g_sync
         logic [1:0] sq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq <= 2'b11;
            else        sq <= {sq[0], rb_in};
         end
         assign rb_out = sq[1];
      end else begin : g_direct
         assign rb_out = rb_in;
      end
   endgenerate

endmodule

// File: rtl/nand_irq_flags.sv
module nand_irq_flags (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       fin,
   input  logic       had_xfer,
   input  logic       err_set,
   input  logic [2:0] clr_bits,
   output logic       cmd_done,
   output logic       xfer_done,
   output logic       err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_done  <= 1'b0;
         xfer_done <= 1'b0;
         err       <= 1'b0;
      end else if (clr) begin
         cmd_done  <= 1'b0;
         xfer_done <= 1'b0;
         err       <= 1'b0;
      end else begin
         if (fin)               cmd_done  <= 1'b1;
         else if (clr_bits[0])  cmd_done  <= 1'b0;
         if (fin && had_xfer)   xfer_done <= 1'b1;
         else if (clr_bits[1])  xfer_done <= 1'b0;
         if (err_set)           err       <= 1'b1;
         else if (clr_bits[2])  err       <= 1'b0;
      end
   end

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
   import nand_seq_pkg::*;
#(
   parameter int LEN_W   = 12,
   parameter int T_W     = 4,
   parameter bit SYNC_RB = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seq_clr,
   input  logic             cmd_wr,
   input  logic [31:0]      cmd_word,
   input  logic [8:0]       cfg_ctl2,
   input  logic [15:0]      cfg_addr_lo,
   input  logic [23:0]      cfg_addr_hi,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic [T_W-1:0]   cfg_tstrobe,
   input  logic [2:0]       irq_clr,
   output logic             busy,
   output logic             irq_cmd_done,
   output logic             irq_xfer_done,
   output logic             err_busy,
   output logic [1:0]       nf_ce_n,
   output logic             nf_cle,
   output logic             nf_ale,
   output logic             nf_we_n,
   output logic             nf_re_n,
   output logic [7:0]       nf_dq_out,
   output logic             nf_dq_oe,
   input  logic [7:0]       nf_dq_in,
   input  logic             nf_rb_n,
   output logic [LEN_W-1:0] buf_addr,
   output logic             buf_wr,
   output logic [7:0]       buf_wdata,
   input  logic [7:0]       buf_rdata
);

   localparam int NA_W   = 3;
   localparam int ADDR_W = 40;

   generate
      if (LEN_W < NA_W) begin : g_bad_len
         $error("LEN_W must cover the address cycle index");
      end
      if (T_W < 1) begin : g_bad_t
         $error("T_W must be at least 1");
      end
   endgenerate

   seq_st_t           st;
   logic [7:0]        op1, op2;
   logic              conf_en, aen, rd, wr, cs;
   logic [NA_W-1:0]   na;
   logic [ADDR_W-1:0] abytes;
   logic [LEN_W-1:0]  len, idx;
   logic [T_W-1:0]    tsel;

   logic s_act, s_low, s_sample, s_done, s_start;
   logic rb, launch, strobe_st, rd_data;
   logic [7:0] abyte;
   seq_st_t after_addr;

   logic unused_cmd_bits;
   assign unused_cmd_bits = ^{cmd_word[24:20], cmd_word[18:8]};

   assign busy   = (st != S_IDLE);
   assign launch = cmd_wr && cmd_word[C1_GO] && !busy;

   always_comb begin
      if (rd)       after_addr = conf_en ? S_CONF : ((len != '0) ? S_DATA : S_FIN);
      else if (wr)  after_addr = (len != '0) ? S_DATA : (conf_en ? S_CONF : S_FIN);
      else          after_addr = conf_en ? S_CONF : S_FIN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;  op1 <= '0;  op2 <= '0;  conf_en <= 1'b0;
         aen <= 1'b0;   rd <= 1'b0; wr <= 1'b0; cs <= 1'b0;
         na <= '0;      abytes <= '0; len <= '0; idx <= '0; tsel <= '0;
      end else if (seq_clr) begin
         st  <= S_IDLE;
         idx <= '0;
      end else begin
         case (st)
            S_IDLE: if (launch) begin
               op1     <= cmd_word[7:0];
               aen     <= cmd_word[C1_AEN];
               na      <= cmd_word[C1_NA_LO +: NA_W];
               rd      <= cmd_word[C1_RD];
               wr      <= cmd_word[C1_WR] & ~cmd_word[C1_RD];
               cs      <= cmd_word[C1_CS];
               op2     <= cfg_ctl2[7:0];
               conf_en <= cfg_ctl2[C2_CONF];
               abytes  <= {cfg_addr_hi, cfg_addr_lo};
               len     <= cfg_len;
               tsel    <= cfg_tstrobe;
               idx     <= '0;
               st      <= S_CMD;
            end
            S_CMD: if (s_done) begin
               st  <= aen ? S_ADDR : after_addr;
               idx <= '0;
            end
            S_ADDR: if (s_done) begin
               if (idx == {{(LEN_W-NA_W){1'b0}}, na}) begin
                  st  <= after_addr;
                  idx <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            S_CONF: if (s_done) st <= S_WLO;
            S_WLO:  if (!rb) st <= S_WHI;
            S_WHI:  if (rb) begin
               st  <= (rd && len != '0) ? S_DATA : S_FIN;
               idx <= '0;
            end
            S_DATA: if (s_done) begin
               if (idx == len - 1'b1) begin
                  st  <= (wr && conf_en) ? S_CONF : S_FIN;
                  idx <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            S_FIN:   st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign strobe_st = (st == S_CMD) || (st == S_ADDR) || (st == S_CONF) || (st == S_DATA);
   assign s_start   = strobe_st && !s_act;
   assign rd_data   = (st == S_DATA) && rd;

   nand_strobe_gen #(.T_W(T_W)) u_strobe (
      .clk(clk), .rst_n(rst_n), .clr(seq_clr), .start(s_start), .tlen(tsel),
      .active(s_act), .low(s_low), .sample(s_sample), .done(s_done)
   );

   nand_rb_sync #(.SYNC(SYNC_RB)) u_rb (
      .clk(clk), .rst_n(rst_n), .rb_in(nf_rb_n), .rb_out(rb)
   );

   nand_irq_flags u_flags (
      .clk(clk), .rst_n(rst_n), .clr(seq_clr), .fin(st == S_FIN),
      .had_xfer(rd || wr), .err_set(cmd_wr && cmd_word[C1_GO] && busy),
      .clr_bits(irq_clr), .cmd_done(irq_cmd_done), .xfer_done(irq_xfer_done),
      .err(err_busy)
   );

   assign abyte = 8'(abytes >> {idx[NA_W-1:0], 3'b000});

   always_comb begin
      case (st)
         S_CMD:   nf_dq_out = op1;
         S_CONF:  nf_dq_out = op2;
         S_ADDR:  nf_dq_out = abyte;
         S_DATA:  nf_dq_out = buf_rdata;
         default: nf_dq_out = 8'h00;
      endcase
   end

   assign nf_dq_oe  = strobe_st && !rd_data;
   assign nf_cle    = (st == S_CMD) || (st == S_CONF);
   assign nf_ale    = (st == S_ADDR);
   assign nf_we_n   = !(s_low && !rd_data);
   assign nf_re_n   = !(s_low && rd_data);
   assign nf_ce_n   = busy ? (cs ? 2'b01 : 2'b10) : 2'b11;
   assign buf_addr  = idx;
   assign buf_wr    = s_sample && rd_data;
   assign buf_wdata = nf_dq_in;

   // R8
   we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nf_we_n && !nf_re_n));

   // R3
   cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nf_cle && nf_ale));

   // R4
   one_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(nf_ce_n) == 1));

   // R10
   err_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n || seq_clr)
      (busy && cmd_wr && cmd_word[C1_GO]) |=> err_busy);

   // R9
   done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || seq_clr)
      $rose(irq_cmd_done) |-> !busy);

   // R5
   wait_after_conf_chk: assert property (@(posedge clk) disable iff (!rst_n || seq_clr)
      (st == S_WLO) |-> ($past(st) == S_CONF || $past(st) == S_WLO));

endmodule

// File: tb/tb_nand_cmd_seq.sv
`timescale 1ns/1ps
module tb_nand_cmd_seq;

   localparam int LEN_W = 12;
   localparam int T_W   = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst_n = 1'b0, seq_clr = 1'b0, cmd_wr = 1'b0;
   logic [31:0]      cmd_word = '0;
   logic [8:0]       cfg_ctl2 = '0;
   logic [15:0]      cfg_addr_lo = '0;
   logic [23:0]      cfg_addr_hi = '0;
   logic [LEN_W-1:0] cfg_len = '0;
   logic [T_W-1:0]   cfg_tstrobe = '0;
   logic [2:0]       irq_clr = '0;
   logic busy, irq_cmd_done, irq_xfer_done, err_busy;
   logic [1:0] nf_ce_n;
   logic nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, buf_wr;
   logic [7:0] nf_dq_out, buf_wdata, buf_rdata;
   logic [7:0] dq_in = 8'h00;
   logic rb_n = 1'b1;
   logic [LEN_W-1:0] buf_addr;

   nand_cmd_seq #(.LEN_W(LEN_W), .T_W(T_W), .SYNC_RB(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .seq_clr(seq_clr), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
      .cfg_ctl2(cfg_ctl2), .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
      .cfg_len(cfg_len), .cfg_tstrobe(cfg_tstrobe), .irq_clr(irq_clr), .busy(busy),
      .irq_cmd_done(irq_cmd_done), .irq_xfer_done(irq_xfer_done), .err_busy(err_busy),
      .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
      .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(dq_in),
      .nf_rb_n(rb_n), .buf_addr(buf_addr), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
      .buf_rdata(buf_rdata)
   );

   function automatic logic [7:0] wpat(input int a);
      return 8'(a * 13) ^ 8'h5A;
   endfunction
   function automatic logic [7:0] rpat(input int k);
      return 8'(k * 37 + 5);
   endfunction

   // page buffer: write side from the design, read side is a pure function
   assign buf_rdata = wpat(int'(buf_addr));
   logic [7:0] cap [0:4095];
   int cap_n = 0;
   always @(posedge clk) if (buf_wr) begin
      cap[buf_addr] <= buf_wdata;
      cap_n <= cap_n + 1;
   end

   // flash model: write-strobe event log, read data, ready/busy
   logic [11:0] ev [0:1023];
   int ev_n = 0, trig_n = 0, rd_total = 0;
   always @(posedge nf_we_n) if (rst_n) begin
      ev[ev_n] = {nf_ce_n, (nf_cle ? 2'd1 : nf_ale ? 2'd2 : 2'd3), nf_dq_out};
      ev_n = ev_n + 1;
      if (nf_cle && (nf_dq_out == 8'h30 || nf_dq_out == 8'h10 || nf_dq_out == 8'hD0))
         trig_n = trig_n + 1;
   end
   always @(negedge nf_re_n) if (rst_n) begin
      dq_in = rpat(rd_total);
      rd_total = rd_total + 1;
   end
   int seen_n = 0, bcnt = 0;
   always @(negedge clk) begin
      if (trig_n != seen_n) begin
         seen_n = trig_n; rb_n = 1'b0; bcnt = 12;
      end else if (bcnt > 0) begin
         bcnt = bcnt - 1;
         if (bcnt == 0) rb_n = 1'b1;
      end
   end

   // strobe low-width log
   int wlog [0:4095];
   int wn = 0, lw = 0;
   always @(negedge clk) begin
      if (!nf_we_n || !nf_re_n) lw = lw + 1;
      else if (lw != 0) begin
         if (wn < 4096) wlog[wn] = lw;
         wn = wn + 1; lw = 0;
      end
   end

   int n_chk = 0, n_bad = 0;
   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   logic [11:0] exv [0:1023];
   int exn, ev_b, rd_b, cap_b, wn_b, x_len, x_t;
   logic x_rd, x_xfer;

   task automatic push(input logic [1:0] ce, input logic [1:0] k, input logic [7:0] v);
      exv[exn] = {ce, k, v};
      exn++;
   endtask

   task automatic start_cmd(input logic [31:0] w, input logic [8:0] c2, input logic [15:0] alo,
                            input logic [23:0] ahi, input int len, input int t);
      logic [39:0] a;
      logic [1:0] ce;
      logic wr;
      a = {ahi, alo};
      ce = w[19] ? 2'b01 : 2'b10;
      x_rd = w[26]; wr = w[25] && !w[26]; x_xfer = w[26] || w[25];
      x_len = len; x_t = t; exn = 0;
      push(ce, 2'd1, w[7:0]);
      if (w[30]) for (int i = 0; i <= int'(w[29:27]); i++) push(ce, 2'd2, a[i*8 +: 8]);
      if (x_rd) begin
         if (c2[8]) push(ce, 2'd1, c2[7:0]);
      end else if (wr) begin
         for (int i = 0; i < len; i++) push(ce, 2'd3, wpat(i));
         if (c2[8]) push(ce, 2'd1, c2[7:0]);
      end else if (c2[8]) push(ce, 2'd1, c2[7:0]);
      ev_b = ev_n; rd_b = rd_total; cap_b = cap_n; wn_b = wn;
      cmd_word = w; cfg_ctl2 = c2; cfg_addr_lo = alo; cfg_addr_hi = ahi;
      cfg_len = LEN_W'(len); cfg_tstrobe = T_W'(t);
      cmd_wr = 1'b1;
      tick(1);
      cmd_wr = 1'b0;
   endtask

   task automatic finish_cmd(input string tag);
      int guard, bad_i, bad_w;
      guard = 0;
      while (!irq_cmd_done && guard < 8000) begin tick(1); guard++; end
      check({tag, " run completes (R9)"}, irq_cmd_done, 1);
      tick(2);
      check({tag, " xfer flag (R9/R12)"}, irq_xfer_done, x_xfer);
      check({tag, " bus event count (R2/R3/R5/R7)"}, ev_n - ev_b, exn);
      bad_i = -1;
      for (int i = 0; i < exn && i < ev_n - ev_b; i++)
         if (bad_i < 0 && ev[ev_b + i] != exv[i]) bad_i = i;
      if (bad_i >= 0) check({tag, " bus event content (R2/R3/R4/R5/R7)"}, ev[ev_b + bad_i], exv[bad_i]);
      else            check({tag, " bus event content (R2/R3/R4/R5/R7)"}, 0, 0);
      check({tag, " read byte count (R6)"}, cap_n - cap_b, x_rd ? x_len : 0);
      bad_i = -1;
      if (x_rd) for (int i = 0; i < x_len; i++) if (bad_i < 0 && cap[i] != rpat(rd_b + i)) bad_i = i;
      if (bad_i >= 0) check({tag, " read data (R6)"}, cap[bad_i], rpat(rd_b + bad_i));
      else            check({tag, " read data (R6)"}, 0, 0);
      bad_w = x_t + 1;
      for (int i = wn_b; i < wn && i < 4096; i++) if (wlog[i] != x_t + 1) bad_w = wlog[i];
      check({tag, " strobe width (R8)"}, bad_w, x_t + 1);
      irq_clr = 3'b011;
      tick(1);
      irq_clr = 3'b000;
      check({tag, " flags cleared (R9)"}, {irq_cmd_done, irq_xfer_done}, 0);
   endtask

   function automatic logic [31:0] mk(input logic [7:0] op, input bit aen, input int na,
                                      input bit r, input bit w, input bit cs);
      logic [31:0] v;
      v = 32'h8000_0000 | {24'h0, op};
      if (aen) v = v | (32'h1 << 30) | (32'(na - 1) << 27);
      if (r)  v = v | (32'h1 << 26);
      if (w)  v = v | (32'h1 << 25);
      if (cs) v = v | (32'h1 << 19);
      return v;
   endfunction

   initial begin
      #(5.0 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int r, kind, na, len, t;
      bit cs, cf;
      tick(5);
      rst_n = 1'b1;
      tick(2);
      // R1 reset state
      check("R1 idle", {busy, nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale}, 7'b0111100);
      check("R1 flags", {irq_cmd_done, irq_xfer_done, err_busy}, 0);

      // R2 write without go bit is ignored
      ev_b = ev_n;
      cmd_word = 32'h4000_0090; cmd_wr = 1'b1; tick(1); cmd_wr = 1'b0; tick(20);
      check("R2 no go bit: busy", busy, 0);
      check("R2 no go bit: no bus events", ev_n - ev_b, 0);

      // R9 ID read: one address cycle, length 4
      start_cmd(mk(8'h90, 1, 1, 1, 0, 0), 9'h000, 16'h0000, 24'h0, 4, 0);
      finish_cmd("R9 id-read");
      // R3/R4/R5/R6 large-page read on chip enable 1, five address cycles
      start_cmd(mk(8'h00, 1, 5, 1, 0, 1), 9'h130, 16'h0840, 24'h12_3456, 16, 1);
      finish_cmd("R6 page-read");
      // R7/R5 program, four address cycles
      start_cmd(mk(8'h80, 1, 4, 0, 1, 0), 9'h110, 16'h0000, 24'h00_0A0B, 12, 2);
      finish_cmd("R7 program");
      // R9 erase: no data phase, xfer flag stays 0
      start_cmd(mk(8'h60, 1, 3, 0, 0, 1), 9'h1D0, 16'hBEEF, 24'h00_0077, 0, 0);
      finish_cmd("R9 erase");
      // R6 both direction bits: read wins
      start_cmd(mk(8'h00, 1, 2, 1, 1, 0), 9'h000, 16'h0123, 24'h0, 6, 0);
      finish_cmd("R6 rd-priority");
      // R12 zero length read
      start_cmd(mk(8'h00, 1, 2, 1, 0, 0), 9'h000, 16'h0001, 24'h0, 0, 0);
      finish_cmd("R12 zero-len");
      // R3 no address cycles
      start_cmd(mk(8'hFF, 0, 1, 0, 0, 0), 9'h000, 16'hAAAA, 24'h0, 0, 0);
      finish_cmd("R3 no-addr");

      // R10 launch while busy
      start_cmd(mk(8'h00, 1, 2, 1, 0, 0), 9'h000, 16'h0010, 24'h0, 10, 1);
      tick(3);
      cmd_word = mk(8'h70, 1, 1, 1, 0, 1); cmd_wr = 1'b1; tick(1); cmd_wr = 1'b0;
      check("R10 err set", err_busy, 1);
      finish_cmd("R10 busy-launch");
      check("R10 err sticky", err_busy, 1);
      irq_clr = 3'b100; tick(1); irq_clr = 3'b000;
      check("R10 err cleared", err_busy, 0);

      // R11 clear mid-run
      start_cmd(mk(8'h00, 1, 4, 1, 0, 1), 9'h130, 16'h0, 24'h1, 20, 2);
      tick(8);
      seq_clr = 1'b1; tick(2); seq_clr = 1'b0; tick(1);
      check("R11 idle after clear", {busy, nf_ce_n, nf_we_n, nf_re_n}, 5'b01111);
      check("R11 flags cleared", {irq_cmd_done, irq_xfer_done, err_busy}, 0);
      while (!rb_n || bcnt != 0) tick(1);
      tick(4);

      // random mix, fixed seed
      r = int'($urandom(32'h00C0_FFEE));
      for (int it = 0; it < 24; it++) begin
         kind = int'($urandom % 4); na = int'($urandom % 5) + 1;
         len = int'($urandom % 24) + 1; t = int'($urandom % 4);
         cs = 1'($urandom); cf = 1'($urandom);
         case (kind)
            0: start_cmd(mk(8'h00, 1, na, 1, 0, cs), cf ? 9'h130 : 9'h000,
                         16'($urandom), 24'($urandom), len, t);
            1: start_cmd(mk(8'h80, 1, na, 0, 1, cs), cf ? 9'h110 : 9'h000,
                         16'($urandom), 24'($urandom), len, t);
            2: start_cmd(mk(8'h60, 1, na, 0, 0, cs), 9'h1D0,
                         16'($urandom), 24'($urandom), 0, t);
            default: start_cmd(mk(8'h70, 1, 1, 1, 0, cs), 9'h000,
                         16'($urandom), 24'h0, 4, t);
         endcase
         finish_cmd("R6/R7/R8 random");
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule